// File: doc/BRIEF.md
# Calendar Time Register Update Engine

This block keeps the time and date of a wall clock in ten byte registers: seconds, minutes, hours, day of week, day of month, month and year, plus three alarm bytes for seconds, minutes and hours. Each pulse on the update input advances the stored time by one second. Carries ripple through every field, and month lengths and a divisible-by-four leap year are respected. Each field is held either as packed BCD or as plain binary, and the hour is held either in 24-hour form or in 12-hour form with a PM flag.

A host reaches the registers through a byte-wide port. An update runs for a fixed number of clock cycles. While it runs the port is fenced off: writes are dropped and reads return zero. A host write that lands in the cycle an update is accepted keeps its value; the update does not overwrite it. When the update finishes, a one-cycle done pulse is raised, together with an alarm pulse when the newly computed time matches the alarm bytes.

Top module: `rtc_cal_engine`

## Requirements
- R1: After a synchronous reset every register reads 00h, except day of week, date and month, which read 01h. busy, done and alarm_hit are low.
- R2: Seconds and minutes count 0..59. A step past 59 wraps to 0 and carries. With fmt_bin=1 the values are binary; with fmt_bin=0 they are packed BCD, tens in bits 7:4 and units in bits 3:0.
- R3: With mode_24h=1 the hour counts 0..23, and a step past 23 wraps to 0 and carries into the date fields.
- R4: With mode_24h=0, bit 7 of the hour is PM and bits 6:0 hold 1..12 in the selected format. The sequence is 12, 1, ..., 11. PM toggles on the step from 11 to 12. A day carry happens only on the step from 11 PM to 12 AM.
- R5: On a day carry, day of week steps 1..7 and wraps from 7 to 1.
- R6: On a day carry, the date wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and 29 for month 2 when year mod 4 = 0, otherwise 28. When the date wraps, the month steps from 12 to 1 with a carry, and the year steps from 99 to 00.
- R7: A request accepted while idle raises busy from the next cycle for exactly UPD_CYCLES cycles. done is high for one cycle right after busy falls. A request made while busy is ignored.
- R8: The register map is 00h seconds, 01h seconds alarm, 02h minutes, 03h minutes alarm, 04h hours, 05h hours alarm, 06h day of week, 07h date, 08h month, 09h year. A read returns data one cycle later. Reads return 00h while busy and at addresses 0Ah-0Fh. Writes are ignored while busy and at addresses 0Ah-0Fh.
- R9: A host write in the same cycle as an accepted request keeps the written value in that register after the update completes.
- R10: alarm_hit pulses together with done when the seconds, minutes and hours bytes of the new time each equal their alarm byte, or when that alarm byte has bits 7:6 = 11 (don't-care).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_req | input | 1 | Advance the time by one second |
| fmt_bin | input | 1 | 1 = binary fields, 0 = BCD fields |
| mode_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| host_addr | input | ADDR_W | Register byte address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, one cycle after host_rd |
| busy | output | 1 | Update in progress, host port fenced |
| done | output | 1 | One-cycle pulse at update completion |
| alarm_hit | output | 1 | One-cycle alarm match pulse with done |

## Verification
A wrong carry or a wrong wrap decision in the step logic stays hidden until the affected register is read back. The bench therefore reads the whole map after every update, so a bad field shows on host_rdata within about a dozen cycles of the update that corrupted it. A fault in the busy counter or in port fencing shows at once on busy, done or host_rdata. The bench compares these every cycle against a behavioural model. A wrong alarm decision shows on alarm_hit in the done cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_time_t;

    localparam int NUM_LOC  = 10;
    localparam int LOC_SEC  = 0;
    localparam int LOC_ASEC = 1;
    localparam int LOC_MIN  = 2;
    localparam int LOC_AMIN = 3;
    localparam int LOC_HOUR = 4;
    localparam int LOC_AHR  = 5;
    localparam int LOC_DOW  = 6;
    localparam int LOC_DATE = 7;
    localparam int LOC_MON  = 8;
    localparam int LOC_YEAR = 9;

    localparam cal_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                       dow: 8'h01, date: 8'h01, mon: 8'h01,
                                       year: 8'h00};

    function automatic logic [7:0] to_bin(logic [7:0] v, logic bin);
        logic [7:0] tens;
        tens = 8'(v[7:4]) * 8'd10;
        return bin ? v : tens + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] from_bin(logic [7:0] b, logic bin);
        logic [7:0] hi;
        logic [7:0] lo;
        hi = b / 8'd10;
        lo = b % 8'd10;
        return bin ? b : {hi[3:0], lo[3:0]};
    endfunction

    function automatic logic [7:0] month_len(logic [7:0] mo, logic leap);
        case (mo)
            8'd2:                      return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

    function automatic logic field_match(logic [7:0] v, logic [7:0] a);
        return (a[7:6] == 2'b11) || (v == a);
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_time_t cur,
    input  logic      fmt_bin,
    input  logic      mode_24h,
    output cal_time_t nxt
);
    logic [7:0] s_b, m_b, h_b, d_b, mo_b, y_b, lim, h_enc;
    logic       c_s, c_m, c_h, c_d, c_mo, pm;

    always_comb begin
        nxt   = cur;
        c_m   = 1'b0;
        c_h   = 1'b0;
        c_d   = 1'b0;
        c_mo  = 1'b0;
        pm    = cur.hour[7];
        h_enc = 8'h00;
        // seconds
        s_b = to_bin(cur.sec, fmt_bin) + 8'd1;
        c_s = (s_b >= 8'd60);
        if (c_s) s_b = 8'd0;
        nxt.sec = from_bin(s_b, fmt_bin);
        // minutes
        m_b = to_bin(cur.min, fmt_bin);
        if (c_s) begin
            if (m_b >= 8'd59) begin
                m_b = 8'd0;
                c_m = 1'b1;
            end else begin
                m_b = m_b + 8'd1;
            end
        end
        nxt.min = from_bin(m_b, fmt_bin);
        // hours
        if (mode_24h) begin
            h_b = to_bin(cur.hour, fmt_bin);
            if (c_m) begin
                if (h_b >= 8'd23) begin
                    h_b = 8'd0;
                    c_h = 1'b1;
                end else begin
                    h_b = h_b + 8'd1;
                end
            end
            nxt.hour = from_bin(h_b, fmt_bin);
        end else begin
            h_b = to_bin({1'b0, cur.hour[6:0]}, fmt_bin);
            if (c_m) begin
                if (h_b == 8'd12) begin
                    h_b = 8'd1;
                end else if (h_b == 8'd11) begin
                    h_b = 8'd12;
                    c_h = pm;
                    pm  = ~pm;
                end else begin
                    h_b = h_b + 8'd1;
                end
            end
            h_enc    = from_bin(h_b, fmt_bin);
            nxt.hour = {pm, h_enc[6:0]};
        end
        // day of week, date, month, year
        mo_b = to_bin(cur.mon, fmt_bin);
        y_b  = to_bin(cur.year, fmt_bin);
        d_b  = to_bin(cur.date, fmt_bin);
        lim  = month_len(mo_b, y_b[1:0] == 2'b00);
        if (c_h) begin
            nxt.dow = (cur.dow >= 8'd7) ? 8'd1 : cur.dow + 8'd1;
            if (d_b >= lim) begin
                d_b = 8'd1;
                c_d = 1'b1;
            end else begin
                d_b = d_b + 8'd1;
            end
        end
        nxt.date = from_bin(d_b, fmt_bin);
        if (c_d) begin
            if (mo_b >= 8'd12) begin
                mo_b = 8'd1;
                c_mo = 1'b1;
            end else begin
                mo_b = mo_b + 8'd1;
            end
        end
        nxt.mon = from_bin(mo_b, fmt_bin);
        if (c_mo) y_b = (y_b >= 8'd99) ? 8'd0 : y_b + 8'd1;
        nxt.year = from_bin(y_b, fmt_bin);
    end
endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
    import rtc_cal_pkg::*;
(
    input  cal_time_t  t,
    input  logic [7:0] alm_s,
    input  logic [7:0] alm_m,
    input  logic [7:0] alm_h,
    output logic       hit
);
    assign hit = field_match(t.sec, alm_s) &&
                 field_match(t.min, alm_m) &&
                 field_match(t.hour, alm_h);
endmodule

// File: rtl/rtc_cal_engine.sv
module rtc_cal_engine
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int UPD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_req,
    input  logic              fmt_bin,
    input  logic              mode_24h,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    output logic              busy,
    output logic              done,
    output logic              alarm_hit
);
    localparam int CNT_W = $clog2(UPD_CYCLES) + 1;

    cal_time_t          cur_t, shadow, step_out;
    logic [7:0]         alm_s, alm_m, alm_h;
    logic [NUM_LOC-1:0] wr_hit, dirty;
    logic [CNT_W-1:0]   cnt;
    logic               busy_q, done_q, alarm_q, alm_match, addr_ok;
    logic [7:0]         rd_mux, rdata_q;

    rtc_cal_step u_step (
        .cur      (cur_t),
        .fmt_bin  (fmt_bin),
        .mode_24h (mode_24h),
        .nxt      (step_out)
    );

    rtc_cal_alarm u_alarm (
        .t     (shadow),
        .alm_s (alm_s),
        .alm_m (alm_m),
        .alm_h (alm_h),
        .hit   (alm_match)
    );

    assign addr_ok = (host_addr < ADDR_W'(NUM_LOC));

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_hit
        assign wr_hit[i] = host_wr && (host_addr == ADDR_W'(i));
    end

    always_comb begin
        case (host_addr)
            ADDR_W'(LOC_SEC):  rd_mux = cur_t.sec;
            ADDR_W'(LOC_ASEC): rd_mux = alm_s;
            ADDR_W'(LOC_MIN):  rd_mux = cur_t.min;
            ADDR_W'(LOC_AMIN): rd_mux = alm_m;
            ADDR_W'(LOC_HOUR): rd_mux = cur_t.hour;
            ADDR_W'(LOC_AHR):  rd_mux = alm_h;
            ADDR_W'(LOC_DOW):  rd_mux = cur_t.dow;
            ADDR_W'(LOC_DATE): rd_mux = cur_t.date;
            ADDR_W'(LOC_MON):  rd_mux = cur_t.mon;
            ADDR_W'(LOC_YEAR): rd_mux = cur_t.year;
            default:           rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_t   <= TIME_RST;
            shadow  <= TIME_RST;
            alm_s   <= 8'h00;
            alm_m   <= 8'h00;
            alm_h   <= 8'h00;
            dirty   <= '0;
            cnt     <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            alarm_q <= 1'b0;
            rdata_q <= 8'h00;
        end else begin
            done_q  <= 1'b0;
            alarm_q <= 1'b0;
            rdata_q <= (host_rd && !busy_q && addr_ok) ? rd_mux : 8'h00;
            if (busy_q) begin
                if (cnt == '0) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    alarm_q <= alm_match;
                    if (!dirty[LOC_SEC])  cur_t.sec  <= shadow.sec;
                    if (!dirty[LOC_MIN])  cur_t.min  <= shadow.min;
                    if (!dirty[LOC_HOUR]) cur_t.hour <= shadow.hour;
                    if (!dirty[LOC_DOW])  cur_t.dow  <= shadow.dow;
                    if (!dirty[LOC_DATE]) cur_t.date <= shadow.date;
                    if (!dirty[LOC_MON])  cur_t.mon  <= shadow.mon;
                    if (!dirty[LOC_YEAR]) cur_t.year <= shadow.year;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else begin
                if (upd_req) begin
                    busy_q <= 1'b1;
                    cnt    <= CNT_W'(UPD_CYCLES - 1);
                    shadow <= step_out;
                    dirty  <= wr_hit;
                end
                if (host_wr) begin
                    case (host_addr)
                        ADDR_W'(LOC_SEC):  cur_t.sec  <= host_wdata;
                        ADDR_W'(LOC_ASEC): alm_s      <= host_wdata;
                        ADDR_W'(LOC_MIN):  cur_t.min  <= host_wdata;
                        ADDR_W'(LOC_AMIN): alm_m      <= host_wdata;
                        ADDR_W'(LOC_HOUR): cur_t.hour <= host_wdata;
                        ADDR_W'(LOC_AHR):  alm_h      <= host_wdata;
                        ADDR_W'(LOC_DOW):  cur_t.dow  <= host_wdata;
                        ADDR_W'(LOC_DATE): cur_t.date <= host_wdata;
                        ADDR_W'(LOC_MON):  cur_t.mon  <= host_wdata;
                        ADDR_W'(LOC_YEAR): cur_t.year <= host_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign host_rdata = rdata_q;
    assign busy       = busy_q;
    assign done       = done_q;
    assign alarm_hit  = alarm_q;

    AST_DONE_AT_BUSY_END: assert property (@(posedge clk) disable iff (rst) $fell(busy_q) |-> done_q); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (busy_q && cnt != '0) |=> busy_q); // R7
    AST_READ_FENCED: assert property (@(posedge clk) disable iff (rst) (busy_q && host_rd) |=> (host_rdata == 8'h00)); // R8
    AST_ALARM_BYTES_HELD: assert property (@(posedge clk) disable iff (rst) busy_q |=> $stable({alm_s, alm_m, alm_h})); // R8
    AST_HOST_KEEPS_SEC: assert property (@(posedge clk) disable iff (rst) (busy_q && cnt == '0 && dirty[LOC_SEC]) |=> $stable(cur_t.sec)); // R9
    AST_ALARM_IN_DONE: assert property (@(posedge clk) disable iff (rst) alarm_q |-> done_q); // R10
endmodule

// File: tb/rtc_cal_engine_test.sv
module rtc_cal_engine_test;
    localparam int UPD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_req = 1'b0, fmt_bin = 1'b0, mode_24h = 1'b1;
    logic [3:0] host_addr = 4'h0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       busy, done, alarm_hit;

    always #10 clk = ~clk;

    rtc_cal_engine #(.ADDR_W(4), .UPD_CYCLES(UPD)) uut (
        .clk(clk), .rst(rst), .upd_req(upd_req), .fmt_bin(fmt_bin),
        .mode_24h(mode_24h), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .busy(busy), .done(done), .alarm_hit(alarm_hit)
    );

    int    vectors = 0, errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // reference model state
    int mm[10];
    int sh[10];
    bit dty[10];
    int m_cnt = 0, m_rdata = 0;
    bit m_busy = 0, m_done = 0, m_alarm = 0;

    function automatic int dec(int v, bit bin);
        return bin ? v : (v / 16) * 10 + (v % 16);
    endfunction

    function automatic int enc(int n, bit bin);
        return bin ? n : (n / 10) * 16 + (n % 10);
    endfunction

    function automatic bit a_ok(int v, int a);
        return ((a / 64) == 3) || (v == a);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void calc_next(bit bin, bit h24);
        int v, lim;
        bit cy, pm;
        for (int i = 0; i < 10; i++) sh[i] = mm[i];
        v = dec(mm[0], bin) + 1; cy = 0;
        if (v >= 60) begin v = 0; cy = 1; end
        sh[0] = enc(v, bin);
        if (cy) begin
            v = dec(mm[2], bin) + 1; cy = 0;
            if (v >= 60) begin v = 0; cy = 1; end
            sh[2] = enc(v, bin);
        end
        if (cy) begin
            if (h24) begin
                v = dec(mm[4], bin) + 1; cy = 0;
                if (v >= 24) begin v = 0; cy = 1; end
                sh[4] = enc(v, bin);
            end else begin
                pm = (mm[4] >= 128);
                v  = dec(mm[4] % 128, bin); cy = 0;
                if (v == 12) v = 1;
                else if (v == 11) begin v = 12; cy = pm; pm = !pm; end
                else v = v + 1;
                sh[4] = enc(v, bin) + (pm ? 128 : 0);
            end
        end
        if (cy) begin
            sh[6] = (mm[6] >= 7) ? 1 : mm[6] + 1;
            lim = days_in(dec(mm[8], bin), dec(mm[9], bin));
            v = dec(mm[7], bin) + 1; cy = 0;
            if (v > lim) begin v = 1; cy = 1; end
            sh[7] = enc(v, bin);
            if (cy) begin
                v = dec(mm[8], bin) + 1; cy = 0;
                if (v > 12) begin v = 1; cy = 1; end
                sh[8] = enc(v, bin);
                if (cy) sh[9] = enc((dec(mm[9], bin) + 1) % 100, bin);
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 10; i++) begin mm[i] = 0; dty[i] = 0; end
            mm[6] = 1; mm[7] = 1; mm[8] = 1;
            m_busy = 0; m_done = 0; m_alarm = 0; m_cnt = 0; m_rdata = 0;
        end else begin
            m_rdata = (host_rd && !m_busy && host_addr < 10) ? mm[host_addr] : 0;
            m_done = 0; m_alarm = 0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_alarm = a_ok(sh[0], mm[1]) && a_ok(sh[2], mm[3]) && a_ok(sh[4], mm[5]);
                    foreach (mm[i]) if (!(i % 2 == 1 && i < 6) && !dty[i]) mm[i] = sh[i];
                end else m_cnt = m_cnt - 1;
            end else begin
                if (upd_req) begin
                    calc_next(fmt_bin, mode_24h);
                    for (int i = 0; i < 10; i++) dty[i] = host_wr && (host_addr == i);
                    m_busy = 1; m_cnt = UPD - 1;
                end
                if (host_wr && host_addr < 10) mm[host_addr] = int'(host_wdata);
            end
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            vectors++;
            if (busy !== m_busy || done !== m_done || alarm_hit !== m_alarm ||
                host_rdata !== 8'(m_rdata)) begin
                errors++;
                $display("FAIL %s: busy/done/alarm/rdata actual %b/%b/%b/%02h expected %b/%b/%b/%02h",
                         cur_req, busy, done, alarm_hit, host_rdata,
                         m_busy, m_done, m_alarm, 8'(m_rdata));
            end
        end
    end

    task automatic drive(bit rq, bit w, bit r, int a, int d);
        @(negedge clk);
        upd_req = rq; host_wr = w; host_rd = r;
        host_addr = 4'(a); host_wdata = 8'(d);
    endtask

    task automatic idle(int n);
        repeat (n) drive(0, 0, 0, 0, 0);
    endtask

    task automatic dump_all();
        for (int a = 0; a < 16; a++) drive(0, 0, 1, a, 0);
        idle(1);
    endtask

    task automatic set_time(int s, int m, int h, int dw, int dt, int mo, int y);
        drive(0, 1, 0, 0, s); drive(0, 1, 0, 2, m); drive(0, 1, 0, 4, h);
        drive(0, 1, 0, 6, dw); drive(0, 1, 0, 7, dt); drive(0, 1, 0, 8, mo);
        drive(0, 1, 0, 9, y); idle(1);
    endtask

    task automatic tick();
        drive(1, 0, 0, 0, 0); idle(UPD + 2); dump_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        cur_req = "R1"; dump_all();
        // R2: seconds/minutes carry, BCD then binary
        cur_req = "R2"; fmt_bin = 0; mode_24h = 1;
        set_time('h58, 'h09, 'h10, 3, 'h15, 'h06, 'h20); tick(); tick();
        fmt_bin = 1; set_time(59, 59, 5, 3, 15, 6, 20); tick();
        // R3: 24-hour day rollover
        cur_req = "R3"; fmt_bin = 0;
        set_time('h59, 'h59, 'h23, 2, 'h10, 'h05, 'h21); tick();
        fmt_bin = 1; set_time(59, 59, 23, 2, 10, 5, 21); tick();
        // R5: day of week wrap
        cur_req = "R5"; set_time(59, 59, 23, 7, 3, 3, 22); tick();
        // R6: month ends, leap, year wrap
        cur_req = "R6"; fmt_bin = 0;
        set_time('h59, 'h59, 'h23, 4, 'h31, 'h12, 'h99); tick();
        set_time('h59, 'h59, 'h23, 4, 'h28, 'h02, 'h04); tick();
        set_time('h59, 'h59, 'h23, 4, 'h29, 'h02, 'h04); tick();
        set_time('h59, 'h59, 'h23, 4, 'h28, 'h02, 'h03); tick();
        set_time('h59, 'h59, 'h23, 4, 'h30, 'h04, 'h03); tick();
        fmt_bin = 1; set_time(59, 59, 23, 4, 30, 11, 7); tick();
        // R4: 12-hour sequence
        cur_req = "R4"; mode_24h = 0; fmt_bin = 0;
        set_time('h59, 'h59, 'h11, 1, 'h10, 'h01, 'h10); tick();
        set_time('h59, 'h59, 'h91, 1, 'h31, 'h01, 'h10); tick();
        set_time('h59, 'h59, 'h12, 1, 'h10, 'h01, 'h10); tick();
        fmt_bin = 1; set_time(59, 59, 'h8B, 5, 28, 2, 1); tick();
        set_time(59, 59, 'h8C, 5, 20, 2, 1); tick();
        mode_24h = 1;
        // R7: request while busy ignored
        cur_req = "R7"; set_time(10, 0, 0, 1, 1, 1, 0);
        drive(1, 0, 0, 0, 0); drive(1, 0, 0, 0, 0); drive(1, 0, 0, 0, 0);
        idle(UPD + 2); dump_all();
        // R8: port fenced during update, unused addresses
        cur_req = "R8";
        drive(0, 1, 0, 12, 'h55); drive(1, 0, 0, 0, 0);
        drive(0, 1, 0, 3, 'h44); drive(0, 0, 1, 0, 0); drive(0, 1, 0, 0, 'h20);
        drive(0, 0, 1, 6, 0); idle(UPD + 2); dump_all();
        // R9: host write colliding with accepted request
        cur_req = "R9"; set_time(59, 59, 23, 7, 31, 12, 99);
        drive(1, 1, 0, 0, 30); idle(UPD + 2); dump_all();
        drive(1, 1, 0, 7, 9); idle(UPD + 2); dump_all();
        // R10: alarm match, don't-care, mismatch
        cur_req = "R10"; set_time(20, 5, 7, 1, 1, 1, 0);
        drive(0, 1, 0, 1, 21); drive(0, 1, 0, 3, 5); drive(0, 1, 0, 5, 7); tick();
        drive(0, 1, 0, 1, 'hC0); drive(0, 1, 0, 3, 'hFF); tick();
        drive(0, 1, 0, 5, 8); tick();
        drive(0, 1, 0, 5, 'hC5); drive(0, 1, 0, 1, 25); tick();
        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule